// File: doc/BRIEF.md
# Sign/Logarithm Multiply-Accumulate Unit

This block multiplies a data sample by a coefficient and adds the product into a running accumulator, with every value held in sign/logarithm form. A value is one sign bit plus an unsigned index `i`, and its magnitude is `d^i` with `0 < d < 1`. A smaller index therefore means a larger amplitude. Multiplication adds the two indices. Addition keeps the index of the larger addend and applies a correction term. That term comes from one of two small tables, selected by whether the signs agree, and indexed by the distance between the two indices.

A filter engine streams operand pairs in with `in_valid`. It raises `clr` at the first tap of each output sample, and it reads the accumulator one cycle after each accepted pair. The all-ones index is reserved to mean exact zero. Products too small to represent fall to that code. Sums that would exceed full scale clamp to index 0 and raise a sticky overflow flag.

Top module: `slmac_core`

## Requirements
- R1: A value is {sign, index}, where sign 1 means negative and the index is `LOG_W` = 8 bits wide. The index 255 (all ones) is the zero code. An accumulator at the zero code always shows sign 0.
- R2: The product sign is the XOR of the two operand signs, and the product index is the sum of the two operand indices. The product is the zero code if either operand is the zero code or the sum exceeds 254.
- R3: Let lo be the smaller of two nonzero addend indices, and k the absolute difference between the indices. With equal signs, the sum keeps that sign and has index lo − A(k). A(k) is defined as follows. Set p = 65536 and replace it k times by floor(p·D/65536), where D = 60293 (d ≈ 0.92 in Q16). Then A(k) is the number of times v = 65536 + p can be replaced by floor(v·D/65536) while it stays ≥ 65536.
- R4: With opposite signs and k = 0, the sum is the zero code. With opposite signs and k > 0, the sum takes the sign of the addend with index lo and has index lo + S(k). S(k) is the number of times m = 65536 can be replaced by floor(m·D/65536) while it stays ≥ 65536 − p, with p as in R3. An index above 254 gives the zero code.
- R5: A zero-code addend leaves the other addend unchanged. A pair whose data index is 255 therefore leaves the accumulator unchanged.
- R6: When a same-sign sum would have an index below 0, the index clamps to 0 and `acc_ovf` is set. `acc_ovf` stays set until `clr`.
- R7: The accumulator updates at the clock edge on which `in_valid` is sampled high. `out_valid` is high during exactly the following cycle. Without `in_valid` or `clr`, the accumulator holds.
- R8: `clr` loads the zero code and clears `acc_ovf`. If `in_valid` is high in the same cycle, the accumulator instead takes that pair's product alone.
- R9: Synchronous active-high `rst` sets the accumulator to the zero code with sign 0, and clears `acc_ovf` and `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Restart the accumulator at zero |
| in_valid | input | 1 | Operand pair is valid this cycle |
| data_sgn | input | 1 | Data sample sign |
| data_idx | input | 8 | Data sample log index |
| coef_sgn | input | 1 | Coefficient sign |
| coef_idx | input | 8 | Coefficient log index |
| out_valid | output | 1 | Accumulator holds a new result |
| acc_sgn | output | 1 | Accumulator sign |
| acc_idx | output | 8 | Accumulator log index |
| acc_ovf | output | 1 | Sticky full-scale overflow |

## Verification
The bench builds the unit with its defaults: 8-bit indices, D = 60293 and a 64-entry correction window. With these values, a run of small-index pairs reaches the clamp at index 0 within a few cycles. Products of mid-range indices cross 254 and fall to the zero code. Index gaps from 0 up past the point where both corrections vanish all come up in the mixed random stream. Exact cancellation, zero operands and `clr` together with `in_valid` are also driven directly.

// File: rtl/slmac_pkg.sv
package slmac_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int LOG_W = 8;
    localparam logic [LOG_W-1:0] ZERO_IDX = '1;
    localparam int MAX_IDX = (1 << LOG_W) - 2;

    typedef struct packed {
        logic             sgn;
        logic [LOG_W-1:0] idx;
    } slog_t;

    localparam slog_t ZERO_VAL = '{sgn: 1'b0, idx: ZERO_IDX};

    // d^k in Q16 by repeated truncating multiplication
    function automatic longint pow_q16(input int k, input int unsigned dq);
        longint p;
        p = 65536;
        for (int i = 0; i < 256; i++)
            if (i < k) p = (p * dq) >> 16;
        return p;
    endfunction

    // steps that 1 + d^k can shrink by d while staying >= 1
    function automatic int unsigned corr_add(input int k, input int unsigned dq);
        longint v;
        longint nv;
        int unsigned c;
        logic go;
        v  = 65536 + pow_q16(k, dq);
        c  = 0;
        go = 1'b1;
        for (int i = 0; i < 255; i++) begin
            nv = (v * dq) >> 16;
            if (go && nv >= 65536) begin
                v = nv;
                c++;
            end else begin
                go = 1'b0;
            end
        end
        return c;
    endfunction

    // steps that 1 can shrink by d while staying >= 1 - d^k
    function automatic int unsigned corr_sub(input int k, input int unsigned dq);
        longint w;
        longint m;
        longint nm;
        int unsigned c;
        logic go;
        w  = 65536 - pow_q16(k, dq);
        m  = 65536;
        c  = 0;
        go = (k != 0);
        for (int i = 0; i < 255; i++) begin
            nm = (m * dq) >> 16;
            if (go && nm >= w) begin
                m = nm;
                c++;
            end else begin
                go = 1'b0;
            end
        end
        return c;
    endfunction
endpackage

// File: rtl/slmac_mul.sv
module slmac_mul
    import slmac_pkg::*;
(
    input  slog_t a,
    input  slog_t b,
    output slog_t p
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [LOG_W:0] idx_sum;

    always_comb begin
        idx_sum = {1'b0, a.idx} + {1'b0, b.idx};
        if (a.idx == ZERO_IDX || b.idx == ZERO_IDX || idx_sum > (LOG_W+1)'(MAX_IDX))
            p = ZERO_VAL;
        else
            p = '{sgn: a.sgn ^ b.sgn, idx: idx_sum[LOG_W-1:0]};
    end
endmodule

// File: rtl/slmac_add.sv
module slmac_add
    import slmac_pkg::*;
#(
    parameter int unsigned D_Q16 = 60293,
    parameter int          TBL_N = 64
) (
    input  slog_t x,
    input  slog_t y,
    output slog_t s,
    output logic  clamp
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int TBL_AW = $clog2(TBL_N);

    logic [LOG_W-1:0] add_tbl [TBL_N];
    logic [LOG_W-1:0] sub_tbl [TBL_N];

    for (genvar g = 0; g < TBL_N; g++) begin : g_tbl
        assign add_tbl[g] = LOG_W'(corr_add(g, D_Q16));
        assign sub_tbl[g] = LOG_W'(corr_sub(g, D_Q16));
    end

    slog_t            hi_mag;
    slog_t            lo_mag;
    logic [LOG_W-1:0] gap;
    logic [LOG_W-1:0] corr;
    logic             in_window;
    logic [LOG_W:0]   widened;

    always_comb begin
        if (x.idx <= y.idx) begin
            hi_mag = x;
            lo_mag = y;
        end else begin
            hi_mag = y;
            lo_mag = x;
        end
        gap       = lo_mag.idx - hi_mag.idx;
        in_window = (gap < LOG_W'(TBL_N));
        corr      = '0;
        if (in_window)
            corr = (x.sgn == y.sgn) ? add_tbl[gap[TBL_AW-1:0]] : sub_tbl[gap[TBL_AW-1:0]];
        widened = {1'b0, hi_mag.idx} + {1'b0, corr};
        clamp   = 1'b0;
        s       = ZERO_VAL;
        if (x.idx == ZERO_IDX) begin
            s = y;
        end else if (y.idx == ZERO_IDX) begin
            s = x;
        end else if (x.sgn == y.sgn) begin
            s.sgn = x.sgn;
            if (corr > hi_mag.idx) begin
                s.idx = '0;
                clamp = 1'b1;
            end else begin
                s.idx = hi_mag.idx - corr;
            end
        end else if (gap != '0 && widened <= (LOG_W+1)'(MAX_IDX)) begin
            s = '{sgn: hi_mag.sgn, idx: widened[LOG_W-1:0]};
        end
        if (s.idx == ZERO_IDX)
            s.sgn = 1'b0;
    end
endmodule

// File: rtl/slmac_core.sv
module slmac_core
    import slmac_pkg::*;
#(
    parameter int unsigned D_Q16 = 60293,
    parameter int          TBL_N = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             in_valid,
    input  logic             data_sgn,
    input  logic [LOG_W-1:0] data_idx,
    input  logic             coef_sgn,
    input  logic [LOG_W-1:0] coef_idx,
    output logic             out_valid,
    output logic             acc_sgn,
    output logic [LOG_W-1:0] acc_idx,
    output logic             acc_ovf
);
    timeunit 1ns;
    timeprecision 1ps;

    slog_t acc_q;
    slog_t prod;
    slog_t base;
    slog_t sum;
    logic  sum_clamp;
    logic  ovf_q;
    logic  vld_q;

    slmac_mul u_mul (
        .a ('{sgn: data_sgn, idx: data_idx}),
        .b ('{sgn: coef_sgn, idx: coef_idx}),
        .p (prod)
    );

    assign base = clr ? ZERO_VAL : acc_q;

    slmac_add #(.D_Q16(D_Q16), .TBL_N(TBL_N)) u_add (
        .x     (base),
        .y     (prod),
        .s     (sum),
        .clamp (sum_clamp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= ZERO_VAL;
            ovf_q <= 1'b0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) begin
                acc_q <= sum;
                ovf_q <= (ovf_q & ~clr) | sum_clamp;
            end else if (clr) begin
                acc_q <= ZERO_VAL;
                ovf_q <= 1'b0;
            end
        end
    end

    assign out_valid = vld_q;
    assign acc_sgn   = acc_q.sgn;
    assign acc_idx   = acc_q.idx;
    assign acc_ovf   = ovf_q;
endmodule

// File: rtl/slmac_chk.sv
module slmac_chk
    import slmac_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             clr,
    input logic             in_valid,
    input logic [LOG_W-1:0] data_idx,
    input logic             out_valid,
    input logic             acc_sgn,
    input logic [LOG_W-1:0] acc_idx,
    input logic             acc_ovf
);
    timeunit 1ns;
    timeprecision 1ps;

    assert_reset_state_R9: assert property (@(posedge clk)
        rst |=> (acc_idx == ZERO_IDX && !acc_sgn && !acc_ovf && !out_valid));

    assert_valid_latency_R7: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !clr) |=> ($stable(acc_idx) && $stable(acc_sgn) && !out_valid));

    assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (clr && !in_valid) |=> (acc_idx == ZERO_IDX && !acc_sgn && !acc_ovf));

    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (acc_ovf && !clr) |=> acc_ovf);

    assert_zero_sign_R1: assert property (@(posedge clk) disable iff (rst)
        (acc_idx == ZERO_IDX) |-> !acc_sgn);

    assert_zero_operand_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !clr && data_idx == ZERO_IDX) |=> ($stable(acc_idx) && $stable(acc_sgn)));
endmodule

bind slmac_core slmac_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .in_valid  (in_valid),
    .data_idx  (data_idx),
    .out_valid (out_valid),
    .acc_sgn   (acc_sgn),
    .acc_idx   (acc_idx),
    .acc_ovf   (acc_ovf)
);

// File: tb/slmac_core_test.sv
module slmac_core_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int DQ = 60293;
    localparam int ZC = 255;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clr = 1'b0;
    logic       in_valid = 1'b0;
    logic       data_sgn = 1'b0;
    logic [7:0] data_idx = 8'd0;
    logic       coef_sgn = 1'b0;
    logic [7:0] coef_idx = 8'd0;
    logic       out_valid;
    logic       acc_sgn;
    logic [7:0] acc_idx;
    logic       acc_ovf;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    int ca_t [256];
    int cs_t [256];
    int e_sgn = 0;
    int e_idx = ZC;
    int e_ovf = 0;
    int e_vld = 0;

    slmac_core uut (
        .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid),
        .data_sgn(data_sgn), .data_idx(data_idx),
        .coef_sgn(coef_sgn), .coef_idx(coef_idx),
        .out_valid(out_valid), .acc_sgn(acc_sgn), .acc_idx(acc_idx), .acc_ovf(acc_ovf)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d cycles expected=<50000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic build_tables();
        for (int k = 0; k < 256; k++) begin
            longint p = 65536;
            longint v;
            longint t;
            int n = 0;
            repeat (k) p = p * DQ / 65536;
            v = 65536 + p;
            t = v * DQ / 65536;
            while (t >= 65536) begin n++; v = t; t = v * DQ / 65536; end
            ca_t[k] = n;
            n = 0;
            if (k > 0) begin
                v = 65536;
                t = v * DQ / 65536;
                while (t >= 65536 - p) begin n++; v = t; t = v * DQ / 65536; end
            end
            cs_t[k] = n;
        end
    endtask

    // R3 R4 R5 R6 model of the log-domain sum
    task automatic model_add(input int as, input int ai, input int bs, input int bi,
                             output int rs, output int ri, output int cl);
        int lo;
        int ls;
        int k;
        cl = 0;
        if (ai == ZC) begin rs = bs; ri = bi; end
        else if (bi == ZC) begin rs = as; ri = ai; end
        else begin
            lo = (ai < bi) ? ai : bi;
            ls = (ai <= bi) ? as : bs;
            k  = (ai > bi) ? ai - bi : bi - ai;
            if (as == bs) begin
                rs = as;
                ri = lo - ca_t[k];
                if (ri < 0) begin ri = 0; cl = 1; end
            end else if (k == 0) begin
                rs = 0; ri = ZC;
            end else begin
                rs = ls; ri = lo + cs_t[k];
                if (ri > 254) begin rs = 0; ri = ZC; end
            end
        end
        if (ri == ZC) rs = 0;
    endtask

    task automatic check(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input string tag, input bit c, input bit v,
                        input int ds, input int di, input int cs, input int ci);
        int ps;
        int pi;
        int bs;
        int bi;
        int rs;
        int ri;
        int cl;
        clr = c; in_valid = v;
        data_sgn = ds[0]; data_idx = 8'(di); coef_sgn = cs[0]; coef_idx = 8'(ci);
        @(posedge clk);
        // R2 product model
        if (di == ZC || ci == ZC || di + ci > 254) begin ps = 0; pi = ZC; end
        else begin ps = ds ^ cs; pi = di + ci; end
        e_vld = v;
        if (c) begin bs = 0; bi = ZC; e_ovf = 0; end
        else begin bs = e_sgn; bi = e_idx; end
        if (v) begin
            model_add(bs, bi, ps, pi, rs, ri, cl);
            e_sgn = rs; e_idx = ri;
            if (cl != 0) e_ovf = 1;
        end else if (c) begin
            e_sgn = 0; e_idx = ZC;
        end
        @(negedge clk);
        check(tag, acc_idx, e_idx, "acc_idx");
        check(tag, acc_sgn, e_sgn, "acc_sgn");
        check(tag, acc_ovf, e_ovf, "acc_ovf");
        check(tag, out_valid, e_vld, "out_valid");
    endtask

    initial begin
        build_tables();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        check("R9", acc_idx, ZC, "acc_idx");
        check("R9", acc_sgn, 0, "acc_sgn");
        check("R9", acc_ovf, 0, "acc_ovf");
        check("R9", out_valid, 0, "out_valid");
        // R2 first product into zero accumulator: 10+20 -> idx 30, neg
        step("R2", 1, 1, 1, 10, 0, 20);
        check("R2", acc_idx, 30, "direct idx");
        // R7 idle holds
        step("R7", 0, 0, 0, 0, 0, 0);
        step("R7", 0, 0, 0, 0, 0, 0);
        // R3 same-sign add, gap 0
        step("R3", 0, 1, 1, 15, 0, 15);
        // R4 opposite sign different magnitude
        step("R4", 0, 1, 0, 40, 0, 5);
        // R4 exact cancellation
        step("R4", 1, 1, 0, 20, 0, 0);
        step("R4", 0, 1, 1, 20, 0, 0);
        check("R4", acc_idx, ZC, "cancel");
        // R5 zero operand leaves accumulator
        step("R5", 0, 1, 0, 50, 0, 1);
        step("R5", 0, 1, 1, ZC, 0, 3);
        step("R5", 0, 1, 1, 4, 0, ZC);
        // R2 product underflow to zero code: 200+100
        step("R2", 0, 1, 0, 200, 0, 100);
        step("R2", 0, 1, 0, 127, 0, 127);
        // R6 overflow clamp and stickiness
        step("R6", 1, 1, 0, 0, 0, 0);
        step("R6", 0, 1, 0, 0, 0, 0);
        check("R6", acc_ovf, 1, "set");
        check("R6", acc_idx, 0, "clamped");
        step("R6", 0, 1, 1, 90, 0, 90);
        step("R6", 0, 0, 0, 0, 0, 0);
        // R8 clr alone, then clr with valid
        step("R8", 1, 0, 0, 0, 0, 0);
        step("R6", 0, 1, 0, 0, 0, 0);
        step("R6", 0, 1, 0, 0, 0, 0);
        step("R8", 1, 1, 1, 7, 1, 8);
        check("R8", acc_ovf, 0, "clear with valid");
        // R1 R3 R4 mixed stream, dense small indices and wide gaps
        for (int n = 0; n < 1500; n++) begin
            int di = (n % 3 == 0) ? int'($urandom_range(0, 255)) : int'($urandom_range(0, 40));
            int ci = (n % 5 == 0) ? int'($urandom_range(0, 255)) : int'($urandom_range(0, 30));
            step("R1", ($urandom_range(0, 15) == 0), ($urandom_range(0, 7) != 0),
                 $urandom_range(0, 1), di, $urandom_range(0, 1), ci);
        end
        // R9 reset in mid-run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R9", acc_idx, ZC, "acc_idx after rst");
        check("R9", acc_ovf, 0, "acc_ovf after rst");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule